// File: doc/BRIEF.md
# Dual-Encoder Tail Bit Multiplexer

This block sits after the two constituent encoders of a parallel concatenated encoder. It shapes their output streams into one block-aligned result. While the data part of a block passes through, it forwards the systematic, first-parity and second-parity symbols of both encoders, one symbol per advancing cycle, and raises output-valid.

When the last data symbol has gone by, the block emits the twelve (or, in parallel mode, eighteen) trellis termination bits. The encoders hand these bits over in one go, as three-step bundles per encoder and per field. In multiplexed mode the block packs the tail into four cycles over three ports and holds the rate at one third. In parallel mode it spends three cycles on each encoder and keeps the other encoder's ports quiet. In that mode the second encoder's systematic tail is also steered onto the first encoder's systematic port.

A per-encoder tail flag marks the cycles that carry each encoder's termination bits. An advance input from downstream freezes every output while it is low. The mode and the block length are taken at the start of each block. The data width is a channel count `CH`, and all channels share the same control.

Top module: `enc_tail_mux`

## Requirements
- R1: While `rst_n` is low, `o_valid`, both tail flags and every data output are zero, and `o_ready_start` is one.
- R2: In the data phase, on each clock edge with `i_adv` high, the six data inputs are captured and appear on the matching outputs after that edge, with `o_valid` high and both tail flags low. `i_len` data edges make up a block, and `i_len` is at least 1.
- R3: In multiplexed mode (`i_mux_mode`=1 at start), let S be S0..S11 = x1,z1,x2,z2,x3,z3,x'1,z'1,x'2,z'2,x'3,z'3. Here x and z are the encoder-1 systematic and first-parity tail steps, primes denote encoder 2, and step j sits at bits [j*CH +: CH] of the tail bundle, counting j from 0. In tail cycle k (0..3), `o_e1_sys`=S(3k), `o_e1_p0`=S(3k+1) and `o_e2_p0`=S(3k+2). The other three data outputs are zero.
- R4: In multiplexed mode, `o_tail1` is high in tail cycles 0 and 1 and `o_tail2` is high in tail cycles 2 and 3, never both at once. `o_valid` stays high for `i_len`+4 advancing cycles.
- R5: In multiplexed mode both second-parity outputs (`o_e1_p1`, `o_e2_p1`) are zero for the whole block.
- R6: In parallel mode, tail cycles 0..2 carry encoder-1 step k on `o_e1_sys`, `o_e1_p0` and `o_e1_p1`, with `o_tail1` high. All three encoder-2 outputs are zero in those cycles.
- R7: In parallel mode, tail cycles 3..5 carry encoder-2 step k-3 on `o_e2_sys`, `o_e2_p0` and `o_e2_p1`, and the same systematic step on `o_e1_sys`. `o_e1_p0` and `o_e1_p1` are zero and `o_tail2` is high. `o_valid` stays high for `i_len`+6 advancing cycles.
- R8: On an edge with `i_adv` low, every output holds its value and the data inputs are not sampled.
- R9: The tail bundles are sampled only on the edge that takes the last data symbol. Their values at any other time have no effect on the outputs.
- R10: `i_len` and `i_mux_mode` are sampled only on the edge where `i_start` is high and `o_ready_start` is high. `o_ready_start` is high only between blocks, and `i_start` has no effect while a block is in progress.
- R11: The advancing edge after the last tail cycle clears `o_valid`, the flags and the data outputs, and raises `o_ready_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| i_start | input | 1 | Begins a block when the block is idle |
| i_mux_mode | input | 1 | 1: four-cycle multiplexed tail, 0: six-cycle parallel tail |
| i_len | input | LEN_W | Data symbols in the block (at least 1) |
| i_adv | input | 1 | Downstream advance; low freezes the outputs |
| i_e1_sys | input | CH | Encoder-1 systematic data |
| i_e1_p0 | input | CH | Encoder-1 first parity |
| i_e1_p1 | input | CH | Encoder-1 second parity |
| i_e2_sys | input | CH | Encoder-2 systematic (interleaved) data |
| i_e2_p0 | input | CH | Encoder-2 first parity |
| i_e2_p1 | input | CH | Encoder-2 second parity |
| i_t1_x | input | 3*CH | Encoder-1 systematic tail, three steps |
| i_t1_z | input | 3*CH | Encoder-1 first-parity tail, three steps |
| i_t1_w | input | 3*CH | Encoder-1 second-parity tail, three steps |
| i_t2_x | input | 3*CH | Encoder-2 systematic tail, three steps |
| i_t2_z | input | 3*CH | Encoder-2 first-parity tail, three steps |
| i_t2_w | input | 3*CH | Encoder-2 second-parity tail, three steps |
| o_ready_start | output | 1 | Idle, a start is accepted |
| o_valid | output | 1 | Data outputs carry a symbol |
| o_tail1 | output | 1 | Encoder-1 termination bits on the outputs |
| o_tail2 | output | 1 | Encoder-2 termination bits on the outputs |
| o_e1_sys | output | CH | Encoder-1 systematic port |
| o_e1_p0 | output | CH | Encoder-1 first-parity port |
| o_e1_p1 | output | CH | Encoder-1 second-parity port |
| o_e2_sys | output | CH | Encoder-2 systematic port |
| o_e2_p0 | output | CH | Encoder-2 first-parity port |
| o_e2_p1 | output | CH | Encoder-2 second-parity port |

## Verification
The assertions assume that `i_len` is never zero at a start. They also assume that the mode register changes only between blocks, which holds because a start is taken only while `o_valid` is low. The stimulus respects both assumptions. Every block length it issues is at least one, and it raises `i_start` only after `o_ready_start` is seen high, apart from a deliberate pulse in the middle of a block that checks R10. While the advance input is low, the stimulus scrambles the data and tail inputs, so any sampling outside the allowed edges shows up at the outputs.

// File: rtl/enc_tail_pkg.sv
// Shared definitions for the dual-encoder tail multiplexer.
// Assumes: termination takes three steps per constituent encoder.
package enc_tail_pkg;
    localparam int TAIL_STEPS = 3;                 // steps per encoder
    localparam int MUX_CYCLES = 4;                 // packed tail length
    localparam int PAR_CYCLES = 2 * TAIL_STEPS;    // parallel tail length
    localparam int STEP_W     = 3;                 // holds 0..PAR_CYCLES-1

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DATA  = 2'd1,
        PH_TAIL  = 2'd2,
        PH_FLUSH = 2'd3
    } etm_phase_e;
endpackage

// File: rtl/etm_phase_ctrl.sv
// Phase sequencer: idle -> data -> tail -> flush -> idle.
// Counts advancing data edges against the latched length, then the tail
// cycles for the latched mode. Assumes a start length of at least 1.
module etm_phase_ctrl
    import enc_tail_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_start,
    input  logic              i_mux_mode,
    input  logic [LEN_W-1:0]  i_len,
    input  logic              i_adv,
    output etm_phase_e        phase,
    output logic [STEP_W-1:0] step,
    output logic              mode_q,
    output logic              take_data,
    output logic              cap_tail
);
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt;
    logic [STEP_W-1:0] last_step;

    // Final tail index depends on the mode latched at start
    assign last_step = mode_q ? STEP_W'(MUX_CYCLES - 1) : STEP_W'(PAR_CYCLES - 1);
    assign take_data = (phase == PH_DATA) && i_adv;
    assign cap_tail  = take_data && (cnt == len_q - LEN_W'(1));

    // Phase, counters and per-block configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            len_q  <= '0;
            cnt    <= '0;
            step   <= '0;
            mode_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (i_start) begin
                        len_q  <= i_len;
                        mode_q <= i_mux_mode;
                        cnt    <= '0;
                        phase  <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (i_adv) begin
                        cnt <= cnt + LEN_W'(1);
                        if (cap_tail) begin
                            step  <= '0;
                            phase <= PH_TAIL;
                        end
                    end
                end
                PH_TAIL: begin
                    if (i_adv) begin
                        step <= step + STEP_W'(1);
                        if (step == last_step) begin
                            phase <= PH_FLUSH;
                        end
                    end
                end
                default: begin
                    if (i_adv) begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/etm_tail_store.sv
// Holds the termination bundles of both encoders for the tail phase.
// Loads all six bundles together on the capture strobe, keeps them otherwise.
module etm_tail_store #(
    parameter int CH = 1,
    localparam int BW = 3 * CH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [BW-1:0] tin [2][3],
    output logic [BW-1:0] tq  [2][3]
);
    for (genvar e = 0; e < 2; e++) begin : g_enc
        for (genvar f = 0; f < 3; f++) begin : g_fld
            // One bundle register per encoder and field
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tq[e][f] <= '0;
                end else if (cap) begin
                    tq[e][f] <= tin[e][f];
                end
            end
        end
    end
endmodule

// File: rtl/etm_tail_sel.sv
// Chooses the port values for one tail cycle.
// Field index: 0 systematic, 1 first parity, 2 second parity.
// Multiplexed mode packs twelve bits over three ports in four cycles;
// parallel mode gives three cycles to each encoder.
module etm_tail_sel
    import enc_tail_pkg::*;
#(
    parameter int CH = 1,
    localparam int BW = 3 * CH
) (
    input  logic              mode,
    input  logic [STEP_W-1:0] step,
    input  logic [BW-1:0]     tq [2][3],
    output logic [CH-1:0]     e1s,
    output logic [CH-1:0]     e1p0,
    output logic [CH-1:0]     e1p1,
    output logic [CH-1:0]     e2s,
    output logic [CH-1:0]     e2p0,
    output logic [CH-1:0]     e2p1,
    output logic              f1,
    output logic              f2
);
    logic [CH-1:0] seq [4 * TAIL_STEPS];
    int            b;
    int            j;

    // Build the packed tail order and pick the slice for this cycle
    always_comb begin
        e1s  = '0;
        e1p0 = '0;
        e1p1 = '0;
        e2s  = '0;
        e2p0 = '0;
        e2p1 = '0;
        f1   = 1'b0;
        f2   = 1'b0;
        b    = 0;
        j    = 0;
        for (int s = 0; s < TAIL_STEPS; s++) begin
            seq[2*s]                  = tq[0][0][s*CH +: CH];
            seq[2*s+1]                = tq[0][1][s*CH +: CH];
            seq[2*TAIL_STEPS + 2*s]   = tq[1][0][s*CH +: CH];
            seq[2*TAIL_STEPS + 2*s+1] = tq[1][1][s*CH +: CH];
        end
        if (mode) begin
            if (step < STEP_W'(MUX_CYCLES)) begin
                b    = 3 * int'(step);
                e1s  = seq[b];
                e1p0 = seq[b+1];
                e2p0 = seq[b+2];
                f1   = (step < STEP_W'(MUX_CYCLES / 2));
                f2   = !f1;
            end
        end else begin
            if (step < STEP_W'(TAIL_STEPS)) begin
                j    = int'(step);
                e1s  = tq[0][0][j*CH +: CH];
                e1p0 = tq[0][1][j*CH +: CH];
                e1p1 = tq[0][2][j*CH +: CH];
                f1   = 1'b1;
            end else if (step < STEP_W'(PAR_CYCLES)) begin
                j    = int'(step) - TAIL_STEPS;
                e1s  = tq[1][0][j*CH +: CH];
                e2s  = tq[1][0][j*CH +: CH];
                e2p0 = tq[1][1][j*CH +: CH];
                e2p1 = tq[1][2][j*CH +: CH];
                f2   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/etm_out_reg.sv
// Output register with load enable; holds when the load is low.
module etm_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Registered output word, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end
endmodule

// File: rtl/enc_tail_mux.sv
// Top: forwards the encoder data streams, then emits the termination bits
// in packed or parallel form, with tail flags and output-valid.
// Assumes upstream holds data steady while i_adv is low, and presents the
// tail bundles together with the last data symbol of a block.
module enc_tail_mux
    import enc_tail_pkg::*;
#(
    parameter int CH    = 1,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_start,
    input  logic             i_mux_mode,
    input  logic [LEN_W-1:0] i_len,
    input  logic             i_adv,
    input  logic [CH-1:0]    i_e1_sys,
    input  logic [CH-1:0]    i_e1_p0,
    input  logic [CH-1:0]    i_e1_p1,
    input  logic [CH-1:0]    i_e2_sys,
    input  logic [CH-1:0]    i_e2_p0,
    input  logic [CH-1:0]    i_e2_p1,
    input  logic [3*CH-1:0]  i_t1_x,
    input  logic [3*CH-1:0]  i_t1_z,
    input  logic [3*CH-1:0]  i_t1_w,
    input  logic [3*CH-1:0]  i_t2_x,
    input  logic [3*CH-1:0]  i_t2_z,
    input  logic [3*CH-1:0]  i_t2_w,
    output logic             o_ready_start,
    output logic             o_valid,
    output logic             o_tail1,
    output logic             o_tail2,
    output logic [CH-1:0]    o_e1_sys,
    output logic [CH-1:0]    o_e1_p0,
    output logic [CH-1:0]    o_e1_p1,
    output logic [CH-1:0]    o_e2_sys,
    output logic [CH-1:0]    o_e2_p0,
    output logic [CH-1:0]    o_e2_p1
);
    localparam int BW = 3 * CH;
    localparam int OW = 3 + 6 * CH;

    etm_phase_e        phase;
    logic [STEP_W-1:0] step;
    logic              mode_q;
    logic              take_data;
    logic              cap_tail;
    logic [BW-1:0]     tin [2][3];
    logic [BW-1:0]     tq  [2][3];
    logic [CH-1:0]     s_e1s, s_e1p0, s_e1p1, s_e2s, s_e2p0, s_e2p1;
    logic              s_f1, s_f2;
    logic              ld;
    logic [OW-1:0]     d_word;
    logic [OW-1:0]     q_word;

    // Gather the tail bundles into the store layout
    always_comb begin
        tin[0][0] = i_t1_x;
        tin[0][1] = i_t1_z;
        tin[0][2] = i_t1_w;
        tin[1][0] = i_t2_x;
        tin[1][1] = i_t2_z;
        tin[1][2] = i_t2_w;
    end

    etm_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_start    (i_start),
        .i_mux_mode (i_mux_mode),
        .i_len      (i_len),
        .i_adv      (i_adv),
        .phase      (phase),
        .step       (step),
        .mode_q     (mode_q),
        .take_data  (take_data),
        .cap_tail   (cap_tail)
    );

    etm_tail_store #(.CH(CH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_tail),
        .tin   (tin),
        .tq    (tq)
    );

    etm_tail_sel #(.CH(CH)) u_sel (
        .mode (mode_q),
        .step (step),
        .tq   (tq),
        .e1s  (s_e1s),
        .e1p0 (s_e1p0),
        .e1p1 (s_e1p1),
        .e2s  (s_e2s),
        .e2p0 (s_e2p0),
        .e2p1 (s_e2p1),
        .f1   (s_f1),
        .f2   (s_f2)
    );

    // Next output word: data pass-through, tail slice, or flush to zero
    always_comb begin
        d_word = '0;
        if (take_data) begin
            d_word = {1'b1, 1'b0, 1'b0, i_e1_sys, i_e1_p0,
                      mode_q ? {CH{1'b0}} : i_e1_p1,
                      i_e2_sys, i_e2_p0,
                      mode_q ? {CH{1'b0}} : i_e2_p1};
        end else if (phase == PH_TAIL) begin
            d_word = {1'b1, s_f1, s_f2, s_e1s, s_e1p0, s_e1p1,
                      s_e2s, s_e2p0, s_e2p1};
        end
    end

    assign ld = i_adv && (phase != PH_IDLE);

    etm_out_reg #(.W(OW)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .d     (d_word),
        .q     (q_word)
    );

    assign {o_valid, o_tail1, o_tail2, o_e1_sys, o_e1_p0, o_e1_p1,
            o_e2_sys, o_e2_p0, o_e2_p1} = q_word;
    assign o_ready_start = (phase == PH_IDLE);
endmodule

// File: rtl/etm_chk.sv
// Property checker for enc_tail_mux, attached by bind.
// Relies on a non-zero start length; mode_q changes only between blocks.
module etm_chk #(
    parameter int CH = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          i_adv,
    input logic          mode_q,
    input logic          o_ready_start,
    input logic          o_valid,
    input logic          o_tail1,
    input logic          o_tail2,
    input logic [CH-1:0] o_e1_sys,
    input logic [CH-1:0] o_e1_p0,
    input logic [CH-1:0] o_e1_p1,
    input logic [CH-1:0] o_e2_sys,
    input logic [CH-1:0] o_e2_p0,
    input logic [CH-1:0] o_e2_p1
);
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(o_tail1 && o_tail2));

    p_flag_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_tail1 || o_tail2) |-> o_valid);

    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(o_tail1) |-> o_tail2);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !i_adv |=> $stable({o_valid, o_tail1, o_tail2, o_e1_sys, o_e1_p0,
                            o_e1_p1, o_e2_sys, o_e2_p0, o_e2_p1}));

    p_third_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && mode_q) |-> (o_e1_p1 == '0 && o_e2_p1 == '0));

    p_e2_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_tail1 && !mode_q) |-> (o_e2_sys == '0 && o_e2_p0 == '0 && o_e2_p1 == '0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        o_ready_start |-> !o_valid);

    p_end_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(o_tail2) |-> (!o_valid && o_ready_start));
endmodule

bind enc_tail_mux etm_chk #(.CH(CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .i_adv         (i_adv),
    .mode_q        (mode_q),
    .o_ready_start (o_ready_start),
    .o_valid       (o_valid),
    .o_tail1       (o_tail1),
    .o_tail2       (o_tail2),
    .o_e1_sys      (o_e1_sys),
    .o_e1_p0       (o_e1_p0),
    .o_e1_p1       (o_e1_p1),
    .o_e2_sys      (o_e2_sys),
    .o_e2_p0       (o_e2_p0),
    .o_e2_p1       (o_e2_p1)
);

// File: tb/enc_tail_mux_test.sv
// Scoreboard bench: the driver queues the expected output word for each
// advancing cycle; a negedge monitor pops and compares as words emerge.
module enc_tail_mux_test;
    localparam int CH    = 3;
    localparam int LEN_W = 13;
    localparam int IW    = 2 + 6 * CH;

    typedef logic [IW-1:0] item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             i_start = 1'b0;
    logic             i_mux_mode = 1'b0;
    logic [LEN_W-1:0] i_len = '0;
    logic             i_adv = 1'b0;
    logic [CH-1:0]    i_e1_sys = '0, i_e1_p0 = '0, i_e1_p1 = '0;
    logic [CH-1:0]    i_e2_sys = '0, i_e2_p0 = '0, i_e2_p1 = '0;
    logic [3*CH-1:0]  i_t1_x = '0, i_t1_z = '0, i_t1_w = '0;
    logic [3*CH-1:0]  i_t2_x = '0, i_t2_z = '0, i_t2_w = '0;
    logic             o_ready_start, o_valid, o_tail1, o_tail2;
    logic [CH-1:0]    o_e1_sys, o_e1_p0, o_e1_p1, o_e2_sys, o_e2_p0, o_e2_p1;

    int    checks = 0;
    int    failures = 0;
    item_t expq[$];
    string tagq[$];
    item_t last_item = '0;
    logic  adv_q = 1'b0;
    int    vcnt = 0, t1cnt = 0, t2cnt = 0;
    logic [CH-1:0] tx1 [3], tz1 [3], tw1 [3], tx2 [3], tz2 [3], tw2 [3];

    enc_tail_mux #(.CH(CH), .LEN_W(LEN_W)) uut (.*);

    always #5 clk = ~clk;

    wire item_t o_word = {o_tail1, o_tail2, o_e1_sys, o_e1_p0, o_e1_p1,
                          o_e2_sys, o_e2_p0, o_e2_p1};

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic item_t mk(input logic f1, input logic f2,
                                 input logic [CH-1:0] a, input logic [CH-1:0] b,
                                 input logic [CH-1:0] c, input logic [CH-1:0] d,
                                 input logic [CH-1:0] e, input logic [CH-1:0] f);
        return {f1, f2, a, b, c, d, e, f};
    endfunction

    task automatic scramble();
        i_e1_sys = CH'($urandom); i_e1_p0 = CH'($urandom); i_e1_p1 = CH'($urandom);
        i_e2_sys = CH'($urandom); i_e2_p0 = CH'($urandom); i_e2_p1 = CH'($urandom);
        i_t1_x = (3*CH)'($urandom); i_t1_z = (3*CH)'($urandom); i_t1_w = (3*CH)'($urandom);
        i_t2_x = (3*CH)'($urandom); i_t2_z = (3*CH)'($urandom); i_t2_w = (3*CH)'($urandom);
    endtask

    // Sample the advance seen by each edge
    always @(posedge clk) adv_q <= i_adv;

    // Monitor: compare each new output word, and frozen words on stalls (R8)
    always @(negedge clk) begin
        if (rst_n && o_valid) begin
            if (adv_q) begin
                if (expq.size() == 0) begin
                    check_eq("R2 unexpected word", 64'(o_word), 64'(0));
                end else begin
                    last_item = expq.pop_front();
                    check_eq(tagq.pop_front(), 64'(o_word), 64'(last_item));
                    vcnt++;
                    if (o_tail1) t1cnt++;
                    if (o_tail2) t2cnt++;
                end
            end else begin
                check_eq("R8 hold", 64'(o_word), 64'(last_item));
            end
        end
    end

    task automatic run_block(input int len, input bit mode, input int stall, input bit poke);
        int steps;
        logic [CH-1:0] s [12];
        logic [CH-1:0] d1, d2, d3, d4, d5, d6;
        steps = mode ? 4 : 6;
        while (!o_ready_start) @(negedge clk);
        check_eq("R10 ready before start", 64'(o_valid), 64'(0));
        vcnt = 0; t1cnt = 0; t2cnt = 0;
        i_start = 1'b1; i_len = LEN_W'(len); i_mux_mode = mode; i_adv = 1'b0;
        @(negedge clk);
        i_start = 1'b0; i_mux_mode = !mode; i_len = LEN_W'(len + 3);  // R10: ignored now
        check_eq("R10 busy after start", 64'(o_ready_start), 64'(0));
        for (int i = 0; i < len; i++) begin
            scramble();
            if (i == len - 1) begin
                for (int j = 0; j < 3; j++) begin
                    tx1[j] = CH'($urandom); tz1[j] = CH'($urandom); tw1[j] = CH'($urandom);
                    tx2[j] = CH'($urandom); tz2[j] = CH'($urandom); tw2[j] = CH'($urandom);
                end
                i_t1_x = {tx1[2], tx1[1], tx1[0]}; i_t1_z = {tz1[2], tz1[1], tz1[0]};
                i_t1_w = {tw1[2], tw1[1], tw1[0]}; i_t2_x = {tx2[2], tx2[1], tx2[0]};
                i_t2_z = {tz2[2], tz2[1], tz2[0]}; i_t2_w = {tw2[2], tw2[1], tw2[0]};
            end
            if (poke && i == 0) i_start = 1'b1;  // R10: start mid-block ignored
            d1 = i_e1_sys; d2 = i_e1_p0; d3 = mode ? '0 : i_e1_p1;
            d4 = i_e2_sys; d5 = i_e2_p0; d6 = mode ? '0 : i_e2_p1;
            i_adv = 1'b1;
            expq.push_back(mk(1'b0, 1'b0, d1, d2, d3, d4, d5, d6));
            tagq.push_back(mode ? "R2/R5 data" : "R2 data");
            @(negedge clk);
            i_start = 1'b0;
            if (stall > 0 && i % stall == 0) begin
                i_adv = 1'b0; scramble(); @(negedge clk);
            end
        end
        for (int j = 0; j < 3; j++) begin
            s[2*j] = tx1[j]; s[2*j+1] = tz1[j]; s[6+2*j] = tx2[j]; s[7+2*j] = tz2[j];
        end
        for (int k = 0; k < steps; k++) begin
            scramble();  // R9: tail inputs now ignored
            i_adv = 1'b1;
            if (mode) begin
                expq.push_back(mk(k < 2, k >= 2, s[3*k], s[3*k+1], '0, '0, s[3*k+2], '0));
                tagq.push_back("R3/R4/R9 packed tail");
            end else if (k < 3) begin
                expq.push_back(mk(1'b1, 1'b0, tx1[k], tz1[k], tw1[k], '0, '0, '0));
                tagq.push_back("R6/R9 parallel tail enc1");
            end else begin
                expq.push_back(mk(1'b0, 1'b1, tx2[k-3], '0, '0, tx2[k-3], tz2[k-3], tw2[k-3]));
                tagq.push_back("R7/R9 parallel tail enc2");
            end
            @(negedge clk);
            if (stall > 0 && k % stall == 1) begin
                i_adv = 1'b0; scramble(); @(negedge clk);
            end
        end
        i_adv = 1'b1;
        @(negedge clk);
        i_adv = 1'b0;
        check_eq("R11 valid cleared", 64'(o_valid), 64'(0));
        check_eq("R11 outputs cleared", 64'(o_word), 64'(0));
        check_eq("R11 ready again", 64'(o_ready_start), 64'(1));
        check_eq(mode ? "R4 valid length" : "R7 valid length", 64'(vcnt), 64'(len + steps));
        check_eq(mode ? "R4 tail1 length" : "R6 tail1 length", 64'(t1cnt), 64'(steps / 2));
        check_eq(mode ? "R4 tail2 length" : "R7 tail2 length", 64'(t2cnt), 64'(steps / 2));
        check_eq("R2 queue drained", 64'(expq.size()), 64'(0));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        i_adv = 1'b1;
        i_start = 1'b1;
        scramble();
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1 valid", 64'(o_valid), 64'(0));
        check_eq("R1 flags", 64'({o_tail1, o_tail2}), 64'(0));
        check_eq("R1 data", 64'(o_word), 64'(0));
        check_eq("R1 ready", 64'(o_ready_start), 64'(1));
        i_start = 1'b0; i_adv = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        run_block(5, 1'b1, 0, 1'b0);
        run_block(7, 1'b0, 2, 1'b1);
        run_block(1, 1'b1, 1, 1'b0);
        run_block(4, 1'b0, 1, 1'b0);
        run_block(12, 1'b1, 3, 1'b1);
        run_block(1, 1'b0, 0, 1'b0);
        run_block(30, 1'b0, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule